// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block sequences the two deepest low-power states of a small 8-bit microcontroller. When the core accepts a halt instruction, the controller reads the oscillator-interrupt enable flag once, at that clock edge. If the flag is set, it enters active halt. In that state the oscillator and its real-time counter keep running, and the CPU and peripheral clocks stop. If the flag is clear, it enters full halt, and every clock stops, the oscillator included. On entry to active halt, the controller drives the core's 2-bit interrupt-mask field to the open value for one cycle, so that a pending or later timer interrupt can end the sleep.

There are two ways out. An interrupt exit has no wait: the clocks return in the next cycle, together with a one-cycle service request. A reset exit keeps the oscillator running and the core gated for a stabilisation wait of 256 or 4096 cycles, chosen by an option bit. A one-cycle reset-vector fetch request follows the wait.

The watchdog is handled by mode. A halt taken with the watchdog active and the enable flag clear is turned into a reset exit. With the flag set, active halt is entered normally and no reset is produced.

Top module: `halt_power_ctrl`

## Requirements
- R1: At the edge where `haltReq` is accepted in run mode, `oscIntEn`=1 selects active halt, with clock enables {cpu,per,osc}=001 from the next cycle. `oscIntEn`=0 with `wdgActive`=0 selects full halt, with enables 000.
- R2: After `rstN` is released and in run mode, all three clock enables are 1 and `maskForce` is 0.
- R3: `maskForce` is 1, with `maskVal`=2'b10, for exactly the first cycle after the halt edge into active halt. It stays 0 on entry to full halt.
- R4: If `rtcIrq` is high during the active-halt entry cycle, the controller wakes at the next edge: `irqService`=1 one cycle later.
- R5: In active halt, `extIrq` has no effect. Only `rtcIrq` or `resetReq` ends it.
- R6: In full halt, `extIrq` or `resetReq` ends it, and `rtcIrq` has no effect.
- R7: An interrupt exit asserts `irqService` for one cycle, starting the cycle after the wake edge, with all clock enables 1. It inserts no wait.
- R8: A reset exit holds enables at 001 and asserts `vectorFetch` for one cycle, exactly T+1 edges after the wake edge. T is 256 when `delaySel`=0 and 4096 when `delaySel`=1, sampled at the wake edge.
- R9: When `resetReq` and a wake interrupt are high at the same edge, the reset path is taken and no `irqService` is produced.
- R10: A halt with `wdgActive`=1 and `oscIntEn`=0 starts the reset wait at the halt edge, followed by `vectorFetch`. A halt with `wdgActive`=1 and `oscIntEn`=1 enters active halt with no `vectorFetch`.
- R11: `oscIntEn` is sampled only at the halt edge. Changing it during halt does not change the mode or its wake sources.
- R12: `resetReq` in run mode has no effect: the clocks stay on and no `vectorFetch` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller |
| haltReq | input | 1 | Core retired a halt instruction (one cycle) |
| oscIntEn | input | 1 | Oscillator-interrupt enable flag |
| rtcIrq | input | 1 | Real-time-counter interrupt |
| extIrq | input | 1 | External interrupt |
| resetReq | input | 1 | Reset wake request |
| wdgActive | input | 1 | Watchdog is running |
| delaySel | input | 1 | Option bit: 0 selects the short wait, 1 the long wait |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscClkEn | output | 1 | Oscillator clock enable |
| maskForce | output | 1 | Override of the interrupt-mask field |
| maskVal | output | 2 | Value forced into the mask field |
| vectorFetch | output | 1 | Request to fetch the reset vector |
| irqService | output | 1 | Request to service the waking interrupt |

## Verification
The assertions assume that `haltReq` comes as a single-cycle pulse while in run mode. They also assume that every input is known from the first edge after reset. The stimulus drives inputs only at falling edges, pulses `haltReq` once per scenario, and then returns to run mode. Wake sources are held for one cycle only, and `oscIntEn` is scrambled straight after the halt edge, so any dependence on a late flag shows up at the outputs. Long waits are drawn rarely, to keep the run short.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_AENTER, ST_AHALT, ST_HALT, ST_DELAY, ST_FETCH, ST_SERVICE
  } pwrState_t;

  typedef struct packed {
    logic load;
    logic count;
  } dlyCtl_t;

  localparam logic [1:0] MASK_OPEN = 2'b10;
endpackage

// File: rtl/hpc_delay.sv
module hpc_delay
  import hpc_pkg::*;
#(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic    clk,
  input  logic    rstN,
  input  dlyCtl_t ctl,
  input  logic    longSel,
  output logic    done
);
  localparam int CW = $clog2(LONG_DLY);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastIdx;

  assign done = ctl.count && (cnt == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      lastIdx <= SHORT_LAST;
    end else if (ctl.load) begin
      cnt     <= '0;
      lastIdx <= longSel ? LONG_LAST : SHORT_LAST;
    end else if (ctl.count && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: the wait counter never runs past its selected terminal index
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.count |-> (cnt <= lastIdx));
endmodule

// File: rtl/hpc_ctrl.sv
module hpc_ctrl
  import hpc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    haltReq,
  input  logic    oscIntEn,
  input  logic    rtcIrq,
  input  logic    extIrq,
  input  logic    resetReq,
  input  logic    wdgActive,
  input  logic    dlyDone,
  output dlyCtl_t ctl,
  output logic    cpuClkEn,
  output logic    perClkEn,
  output logic    oscClkEn,
  output logic    maskForce,
  output logic [1:0] maskVal,
  output logic    vectorFetch,
  output logic    irqService
);
  pwrState_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:
        if (haltReq) begin
          if (oscIntEn)       nxt = ST_AENTER;
          else if (wdgActive) nxt = ST_DELAY;
          else                nxt = ST_HALT;
        end
      ST_AENTER, ST_AHALT: begin
        if (resetReq)    nxt = ST_DELAY;
        else if (rtcIrq) nxt = ST_SERVICE;
        else             nxt = ST_AHALT;
      end
      ST_HALT: begin
        if (resetReq)    nxt = ST_DELAY;
        else if (extIrq) nxt = ST_SERVICE;
      end
      ST_DELAY:   if (dlyDone) nxt = ST_FETCH;
      ST_FETCH:   nxt = ST_RUN;
      ST_SERVICE: nxt = ST_RUN;
      default:    nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxt;
  end

  always_comb begin
    ctl.load  = (nxt == ST_DELAY) && (state != ST_DELAY);
    ctl.count = (state == ST_DELAY);
  end

  always_comb begin
    cpuClkEn    = (state == ST_RUN) || (state == ST_FETCH) || (state == ST_SERVICE);
    perClkEn    = cpuClkEn;
    oscClkEn    = (state != ST_HALT);
    maskForce   = (state == ST_AENTER);
    maskVal     = maskForce ? MASK_OPEN : 2'b00;
    vectorFetch = (state == ST_FETCH);
    irqService  = (state == ST_SERVICE);
  end

  // R1: the mask override only follows a halt taken with the flag set
  assert_mask_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    maskForce |-> $past(haltReq && oscIntEn));
  // R3: the override lasts a single cycle
  assert_mask_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    maskForce |=> !maskForce);
  // R2: the core never runs on a stopped oscillator
  assert_clk_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> oscClkEn);
  // R8: a vector fetch only follows a completed wait
  assert_fetch_after_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    vectorFetch |-> $past(dlyDone));
  // R9: a service request never coincides with a reset request at the wake edge
  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqService |-> !$past(resetReq));
  // R5: a wake out of active halt is caused by the timer interrupt
  assert_ahalt_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqService && $past(state == ST_AHALT)) |-> $past(rtcIrq));
endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
  import hpc_pkg::*;
#(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       oscIntEn,
  input  logic       rtcIrq,
  input  logic       extIrq,
  input  logic       resetReq,
  input  logic       wdgActive,
  input  logic       delaySel,
  output logic       cpuClkEn,
  output logic       perClkEn,
  output logic       oscClkEn,
  output logic       maskForce,
  output logic [1:0] maskVal,
  output logic       vectorFetch,
  output logic       irqService
);
  dlyCtl_t dlyCtl;
  logic    dlyDone;

  hpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .oscIntEn(oscIntEn),
    .rtcIrq(rtcIrq), .extIrq(extIrq), .resetReq(resetReq),
    .wdgActive(wdgActive), .dlyDone(dlyDone), .ctl(dlyCtl),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .oscClkEn(oscClkEn),
    .maskForce(maskForce), .maskVal(maskVal),
    .vectorFetch(vectorFetch), .irqService(irqService)
  );

  hpc_delay #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_delay (
    .clk(clk), .rstN(rstN), .ctl(dlyCtl), .longSel(delaySel), .done(dlyDone)
  );
endmodule

// File: tb/sim_halt_power_ctrl.sv
`timescale 1ns/1ps
module sim_halt_power_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, haltReq, oscIntEn, rtcIrq, extIrq, resetReq, wdgActive, delaySel;
  logic cpuClkEn, perClkEn, oscClkEn, maskForce, vectorFetch, irqService;
  logic [1:0] maskVal;

  halt_power_ctrl u0 (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .oscIntEn(oscIntEn),
    .rtcIrq(rtcIrq), .extIrq(extIrq), .resetReq(resetReq),
    .wdgActive(wdgActive), .delaySel(delaySel),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .oscClkEn(oscClkEn),
    .maskForce(maskForce), .maskVal(maskVal),
    .vectorFetch(vectorFetch), .irqService(irqService)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  function automatic int expTerm(bit sel);
    return sel ? 4096 : 256;
  endfunction

  // 0 run, 1 active halt / wait, 2 full halt
  function automatic int expClk(int mode);
    case (mode)
      0: return 3'b111;
      1: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int clks();
    return {cpuClkEn, perClkEn, oscClkEn};
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitFetch(bit sel, string req);
    int n = 1;
    bit sawSvc = 0;
    while (!vectorFetch && n < 5000) begin
      if (irqService) sawSvc = 1;
      if (n == 2) chk({req, " clocks during wait"}, clks(), expClk(1));
      tick();
      n++;
    end
    chk({req, " wait length"}, n, expTerm(sel) + 1);
    chk({req, " clocks at fetch"}, clks(), expClk(0));
    chk("R9 no service on reset path", int'(sawSvc | irqService), 0);
    tick();
    chk({req, " fetch single cycle"}, int'(vectorFetch), 0);
  endtask

  task automatic runScenario(bit mode, bit wdg, bit pend, int wake, bit sel);
    chk("R2 run clocks", clks(), expClk(0));
    chk("R2 run no override", int'(maskForce), 0);
    haltReq = 1; oscIntEn = mode; wdgActive = wdg; delaySel = sel;
    tick();
    haltReq = 0; oscIntEn = 1'($urandom % 2); // R11 flag scrambled after the halt edge
    if (mode) begin
      chk("R3 override on entry", int'(maskForce), 1);
      chk("R3 mask value", int'(maskVal), 2);
      chk("R1 active-halt clocks", clks(), expClk(1));
      if (pend) begin
        rtcIrq = 1;
        tick();
        rtcIrq = 0;
        chk("R4 immediate wake", int'(irqService), 1);
        chk("R7 clocks on service", clks(), expClk(0));
        tick();
        chk("R7 service single cycle", int'(irqService), 0);
        return;
      end
      tick();
      chk("R3 override single cycle", int'(maskForce), 0);
      chk("R10 no fetch in active halt", int'(vectorFetch), 0);
      chk("R11 active-halt clocks kept", clks(), expClk(1));
      extIrq = 1;
      tick();
      extIrq = 0;
      chk("R5 ext irq ignored", int'(irqService), 0);
      chk("R5 clocks unchanged", clks(), expClk(1));
    end else if (wdg) begin
      chk("R10 no override", int'(maskForce), 0);
      waitFetch(sel, "R10");
      return;
    end else begin
      chk("R1 full-halt clocks", clks(), expClk(2));
      chk("R3 no override in full halt", int'(maskForce), 0);
      rtcIrq = 1;
      tick();
      rtcIrq = 0;
      chk("R6 rtc irq ignored", int'(irqService), 0);
      chk("R6 clocks still off", clks(), expClk(2));
    end
    delaySel = sel;
    if (wake != 1) begin
      if (mode) rtcIrq = 1;
      else extIrq = 1;
    end
    if (wake != 0) resetReq = 1;
    tick();
    rtcIrq = 0; extIrq = 0; resetReq = 0; delaySel = 1'($urandom % 2);
    if (wake == 0) begin
      chk("R7 service without wait", int'(irqService), 1);
      chk("R7 clocks on service", clks(), expClk(0));
      tick();
      chk("R7 service single cycle", int'(irqService), 0);
    end else begin
      waitFetch(sel, wake == 2 ? "R9" : "R8");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; haltReq = 0; oscIntEn = 0; rtcIrq = 0; extIrq = 0;
    resetReq = 0; wdgActive = 0; delaySel = 0;
    tick(); tick();
    rstN = 1;
    tick();
    chk("R2 reset clocks", clks(), expClk(0));
    chk("R2 reset no fetch", int'(vectorFetch | irqService), 0);
    // R12: reset request while running
    resetReq = 1;
    tick();
    resetReq = 0;
    chk("R12 clocks stay on", clks(), expClk(0));
    tick();
    chk("R12 no fetch", int'(vectorFetch), 0);
    // directed corners
    runScenario(1, 1, 0, 1, 1);
    runScenario(0, 0, 0, 0, 0);
    runScenario(0, 1, 0, 0, 0);
    runScenario(1, 0, 1, 0, 0);
    runScenario(1, 0, 0, 2, 0);
    runScenario(0, 0, 0, 2, 0);
    runScenario(0, 0, 0, 1, 1);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      bit m = 1'($urandom % 2);
      runScenario(m, 1'($urandom % 2), m && ($urandom % 4 == 0),
                  int'($urandom % 3), ($urandom % 6 == 0));
      tick();
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule